// File: doc/BRIEF.md
# Compare-and-Exchange Execution Unit

This unit carries out one atomic-style compare-and-exchange on a destination operand that is 8, 16 or 32 bits wide, or on a 64-bit pair made of two 32-bit words. The destination is compared with the accumulator of the same width. If they are equal, the source register value goes to the destination. If they differ, the destination value goes into the accumulator and the destination is left as it was. The unit receives a resolved address, an operand size code and a flag that says whether the destination is a register. It returns the updated accumulator words, a flag vector, a cycle-cost figure and an abort indication, all in a single-cycle `done` pulse.

A memory destination is read and written over one request channel with a valid/ready handshake. Back-pressure rules: once `req_valid` is high, the unit holds `req_valid`, `req_write`, `req_addr`, `req_size` and `req_wdata` steady until a cycle in which `req_ready` is high. The transfer takes place at that clock edge. Only one read is ever outstanding. Read data comes back on `rsp_valid`, which the unit accepts in any cycle while it waits. A write is complete once it is accepted; no write response exists. For 8- and 16-bit operands the operand sits in the low bits of `rsp_data` and `req_wdata`, and `req_size` gives the width. A register destination is passed in on `dst_reg_i`, and any write-back to it comes out on `dst_wr`/`dst_wdata`.

Size codes on `op_size`: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit, 3 is the 64-bit pair. Flag vector bit positions: 0 carry, 1 parity, 2 half-carry (borrow out of bit 3), 3 zero, 4 sign, 5 overflow.

Top module: `cx_unit`

## Requirements
- R1: For sizes 0 to 2, `flags_o` reflects the subtraction accumulator minus destination, both taken at the operand width. Carry is the unsigned borrow. Zero, sign and overflow come from the width's result. Half-carry is the borrow out of bit 3. Parity is 1 when the low byte of the result holds an even number of ones.
- R2: On a match, the source value (its low bits at the operand width) is written once to the destination address, and the accumulator outputs equal the accumulator inputs.
- R3: On a mismatch, the low operand-width bits of `acc_lo_o` take the destination value, the upper bits keep the accumulator input, and no write is issued.
- R4: The 64-bit form reads the word at `op_addr` first and the word at `op_addr+4` second. It compares them with `acc_lo_i` and `acc_hi_i` respectively.
- R5: When the 64-bit form matches, it writes `src_lo_i` to `op_addr` and then `src_hi_i` to `op_addr+4`. On a mismatch it sets `acc_lo_o`/`acc_hi_o` to the two words read and writes nothing.
- R6: The 64-bit form sets `flags_o` to `flags_i` with only bit 3 changed: 1 on a full 64-bit match, 0 otherwise.
- R7: With `done`, `cycles_o` is REG_CYC (6) for a register destination and MEM_CYC (10) for a memory destination. The 64-bit form always counts as a memory destination, whatever the value of `op_is_reg`.
- R8: A read response with `rsp_fault` set ends the operation. `done` and `aborted` are then high together, no write is issued, `dst_wr` stays low, and `acc_lo_o`, `acc_hi_o` and `flags_o` equal their inputs.
- R9: A register destination (`op_is_reg`=1, size 0 to 2) issues no memory request and gives `done` in the cycle after `start`. On a match it raises `dst_wr`, with `dst_wdata` set to `dst_reg_i` whose low operand-width bits are replaced by the source.
- R10: While `req_valid` is high and `req_ready` is low, the request fields stay unchanged in the next cycle. No request is raised while the unit is idle.
- R11: `done` lasts one cycle, after which the unit is idle. A `start` that arrives while `busy` is high is ignored. Operands are captured when `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| op_size | input | 2 | Operand size code |
| op_is_reg | input | 1 | Destination is a register |
| op_addr | input | ADDR_W | Destination address |
| acc_lo_i | input | 32 | Accumulator (low word of the pair) |
| acc_hi_i | input | 32 | High accumulator word of the pair |
| src_lo_i | input | 32 | Source value (low word of the pair) |
| src_hi_i | input | 32 | High source word of the pair |
| dst_reg_i | input | 32 | Register destination value |
| flags_i | input | 6 | Current flag vector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | Operation ended on a fault (with done) |
| acc_lo_o | output | 32 | Updated accumulator low word |
| acc_hi_o | output | 32 | Updated accumulator high word |
| flags_o | output | 6 | Updated flag vector |
| cycles_o | output | CNT_W | Cycle cost (with done, else 0) |
| dst_wr | output | 1 | Register destination write strobe |
| dst_wdata | output | 32 | Register destination write value |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_write | output | 1 | Request is a write |
| req_addr | output | ADDR_W | Request address |
| req_size | output | 2 | Request width code (0 to 2) |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 32 | Read response data |
| rsp_fault | input | 1 | Read response carries a fault |

## Verification
The bench goes after the comparisons that depend on operand width. It uses narrow operands whose upper accumulator bits differ from memory, and values whose differences give signed overflow and a half-carry borrow. A design that compared or merged at the wrong width would then report a false match or overwrite accumulator bits that must be kept. For the 64-bit pair it covers a low-word-equal, high-word-different mismatch and a fault on the second read: a design that judged the match from the low word, or wrote before both reads had completed, would issue memory writes. Random back-pressure and response delays, plus a stray `start` in the middle of an operation, catch request fields that change before they are accepted and operands that are taken while the unit is busy.

// File: rtl/cx_pkg.sv
package cx_pkg;

  localparam int WORD_W = 32;
  localparam int FLAG_W = 6;

  // flag vector bit positions
  localparam int FL_C = 0;
  localparam int FL_P = 1;
  localparam int FL_A = 2;
  localparam int FL_Z = 3;
  localparam int FL_S = 4;
  localparam int FL_O = 5;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_D = 2'd2,
    SZ_Q = 2'd3
  } cx_size_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_WT_LO,
    ST_RD_HI,
    ST_WT_HI,
    ST_CMP,
    ST_WR_LO,
    ST_WR_HI,
    ST_FIN
  } cx_state_e;

  function automatic logic [WORD_W-1:0] size_mask(cx_size_e s);
    case (s)
      SZ_B:    return 32'h0000_00FF;
      SZ_W:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cx_flags.sv
module cx_flags
  import cx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  cx_size_e          size,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  output logic [FLAG_W-1:0] flags
);

  localparam int NW = 3;

  logic [NW-1:0][FLAG_W-1:0] cand;

  for (genvar g = 0; g < NW; g++) begin : g_width
    localparam int SW = 8 << g;
    logic [SW-1:0] ai, bi, di;
    logic cf, pf, af, zf, sf, of;
    assign ai = a[SW-1:0];
    assign bi = b[SW-1:0];
    assign di = ai - bi;
    assign cf = ai < bi;
    assign pf = ~^di[7:0];
    assign af = ai[4] ^ bi[4] ^ di[4];
    assign zf = (di == '0);
    assign sf = di[SW-1];
    assign of = (ai[SW-1] ^ bi[SW-1]) & (di[SW-1] ^ ai[SW-1]);
    assign cand[g] = {of, sf, zf, af, pf, cf};
  end

  always_comb begin
    case (size)
      SZ_B:    flags = cand[0];
      SZ_W:    flags = cand[1];
      default: flags = cand[2];
    endcase
  end

endmodule

// File: rtl/cx_seq.sv
module cx_seq
  import cx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go,
  input  logic     go_reg,
  input  cx_size_e size_q,
  input  logic     match,
  input  logic     req_ready,
  input  logic     rsp_valid,
  input  logic     rsp_fault,
  output logic     busy,
  output logic     done,
  output logic     aborted,
  output logic     req_valid,
  output logic     req_write,
  output logic     hi_sel,
  output logic     cap_lo,
  output logic     cap_hi
);

  cx_state_e state, state_nx;
  logic      abort_q;
  logic      pair;

  assign pair = (size_q == SZ_Q);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (go) state_nx = go_reg ? ST_FIN : ST_RD_LO;
      ST_RD_LO: if (req_ready) state_nx = ST_WT_LO;
      ST_WT_LO: if (rsp_valid) begin
        if (rsp_fault)  state_nx = ST_FIN;
        else if (pair)  state_nx = ST_RD_HI;
        else            state_nx = ST_CMP;
      end
      ST_RD_HI: if (req_ready) state_nx = ST_WT_HI;
      ST_WT_HI: if (rsp_valid) state_nx = rsp_fault ? ST_FIN : ST_CMP;
      ST_CMP:   state_nx = match ? ST_WR_LO : ST_FIN;
      ST_WR_LO: if (req_ready) state_nx = pair ? ST_WR_HI : ST_FIN;
      ST_WR_HI: if (req_ready) state_nx = ST_FIN;
      ST_FIN:   state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      abort_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (go) begin
        abort_q <= 1'b0;
      end else if ((state == ST_WT_LO || state == ST_WT_HI) && rsp_valid && rsp_fault) begin
        abort_q <= 1'b1;
      end
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign aborted   = done && abort_q;
  assign req_valid = (state == ST_RD_LO) || (state == ST_RD_HI) ||
                     (state == ST_WR_LO) || (state == ST_WR_HI);
  assign req_write = (state == ST_WR_LO) || (state == ST_WR_HI);
  assign hi_sel    = (state == ST_RD_HI) || (state == ST_WR_HI);
  assign cap_lo    = (state == ST_WT_LO) && rsp_valid && !rsp_fault;
  assign cap_hi    = (state == ST_WT_HI) && rsp_valid && !rsp_fault;

endmodule

// File: rtl/cx_unit.sv
module cx_unit
  import cx_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int REG_CYC = 6,
  parameter int MEM_CYC = 10,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op_size,
  input  logic              op_is_reg,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [31:0]       acc_lo_i,
  input  logic [31:0]       acc_hi_i,
  input  logic [31:0]       src_lo_i,
  input  logic [31:0]       src_hi_i,
  input  logic [31:0]       dst_reg_i,
  input  logic [5:0]        flags_i,
  output logic              busy,
  output logic              done,
  output logic              aborted,
  output logic [31:0]       acc_lo_o,
  output logic [31:0]       acc_hi_o,
  output logic [5:0]        flags_o,
  output logic [CNT_W-1:0]  cycles_o,
  output logic              dst_wr,
  output logic [31:0]       dst_wdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        req_size,
  output logic [31:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_data,
  input  logic              rsp_fault
);

  localparam logic [ADDR_W-1:0] HI_OFS = ADDR_W'(WORD_W / 8);

  cx_size_e          size_in, size_q;
  logic              reg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       acc_lo_q, acc_hi_q, src_lo_q, src_hi_q;
  logic [31:0]       dst_lo_q, dst_hi_q;
  logic [5:0]        flags_q;
  logic [31:0]       mask_q, mask_in;
  logic              go, go_reg, match, hi_sel, cap_lo, cap_hi;
  logic              lo_eq, hi_eq, pair;
  logic [5:0]        sub_flags;

  assign size_in = cx_size_e'(op_size);
  assign mask_in = size_mask(size_in);
  assign go      = start && !busy;
  assign go_reg  = op_is_reg && (size_in != SZ_Q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q   <= SZ_B;
      reg_q    <= 1'b0;
      addr_q   <= '0;
      acc_lo_q <= '0;
      acc_hi_q <= '0;
      src_lo_q <= '0;
      src_hi_q <= '0;
      flags_q  <= '0;
      dst_lo_q <= '0;
      dst_hi_q <= '0;
    end else begin
      if (go) begin
        size_q   <= size_in;
        reg_q    <= go_reg;
        addr_q   <= op_addr;
        acc_lo_q <= acc_lo_i;
        acc_hi_q <= acc_hi_i;
        src_lo_q <= src_lo_i;
        src_hi_q <= src_hi_i;
        flags_q  <= flags_i;
        dst_lo_q <= dst_reg_i & mask_in;
      end
      if (cap_lo) dst_lo_q <= rsp_data & mask_q;
      if (cap_hi) dst_hi_q <= rsp_data;
    end
  end

  assign mask_q = size_mask(size_q);
  assign pair   = (size_q == SZ_Q);
  assign lo_eq  = ((acc_lo_q ^ dst_lo_q) & mask_q) == '0;
  assign hi_eq  = (acc_hi_q == dst_hi_q);
  assign match  = lo_eq && (!pair || hi_eq);

  cx_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .go_reg    (go_reg),
    .size_q    (size_q),
    .match     (match),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .busy      (busy),
    .done      (done),
    .aborted   (aborted),
    .req_valid (req_valid),
    .req_write (req_write),
    .hi_sel    (hi_sel),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi)
  );

  cx_flags #(.W(WORD_W)) u_flags (
    .size  (size_q),
    .a     (acc_lo_q),
    .b     (dst_lo_q),
    .flags (sub_flags)
  );

  // memory request fields
  assign req_addr  = hi_sel ? addr_q + HI_OFS : addr_q;
  assign req_size  = pair ? SZ_D : size_q;
  assign req_wdata = hi_sel ? src_hi_q : (src_lo_q & mask_q);

  // results
  always_comb begin
    acc_lo_o = acc_lo_q;
    acc_hi_o = acc_hi_q;
    flags_o  = flags_q;
    if (!aborted) begin
      if (!match) begin
        acc_lo_o = (acc_lo_q & ~mask_q) | dst_lo_q;
        if (pair) acc_hi_o = dst_hi_q;
      end
      if (pair) flags_o[FL_Z] = match;
      else      flags_o = sub_flags;
    end
  end

  assign dst_wr    = done && reg_q && match;
  assign dst_wdata = (dst_reg_i & ~mask_q) | (src_lo_q & mask_q);
  assign cycles_o  = !done ? '0 : (reg_q ? CNT_W'(REG_CYC) : CNT_W'(MEM_CYC));

endmodule

// File: rtl/cx_unit_chk.sv
module cx_unit_chk #(
  parameter int ADDR_W  = 32,
  parameter int REG_CYC = 6,
  parameter int MEM_CYC = 10,
  parameter int CNT_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              aborted,
  input logic              dst_wr,
  input logic [CNT_W-1:0]  cycles_o,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic [31:0]       req_wdata
);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write)
                                && $stable(req_wdata) && $stable(req_size));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> done && !dst_wr && !req_valid);

  // R7
  budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles_o == CNT_W'(REG_CYC)) || (cycles_o == CNT_W'(MEM_CYC)));

  // R9
  reg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr |-> done && !aborted && (cycles_o == CNT_W'(REG_CYC)));

endmodule

bind cx_unit cx_unit_chk #(
  .ADDR_W  (ADDR_W),
  .REG_CYC (REG_CYC),
  .MEM_CYC (MEM_CYC),
  .CNT_W   (CNT_W)
) u_chk (.*);

// File: tb/tb_cx_unit.sv
module tb_cx_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op_size = '0;
  logic        op_is_reg = 1'b0;
  logic [31:0] op_addr = '0;
  logic [31:0] acc_lo_i = '0, acc_hi_i = '0, src_lo_i = '0, src_hi_i = '0, dst_reg_i = '0;
  logic [5:0]  flags_i = '0;
  logic        busy, done, aborted, dst_wr, req_valid, req_write;
  logic [31:0] acc_lo_o, acc_hi_o, dst_wdata, req_addr, req_wdata;
  logic [5:0]  flags_o;
  logic [3:0]  cycles_o;
  logic [1:0]  req_size;
  logic        req_ready = 1'b0, rsp_valid = 1'b0, rsp_fault = 1'b0;
  logic [31:0] rsp_data = '0;

  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  cx_unit dut (.*);

  // ---------------- memory model ----------------
  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_rd[$];
  logic [31:0] exp_wa[$];
  logic [31:0] exp_wd[$];
  int          fault_at = -1;
  int          rd_idx = 0;
  logic        rsp_pend = 1'b0;
  int          rsp_cd = 0;
  logic [31:0] rsp_addr_p = '0;
  logic        rsp_fault_p = 1'b0;
  logic        prev_v = 1'b0;
  logic [31:0] prev_a = '0, prev_d = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return {a[15:0], ~a[15:0]};
  endfunction

  always @(negedge clk) begin
    rsp_valid = 1'b0;
    rsp_fault = 1'b0;
    if (rsp_pend) begin
      if (rsp_cd == 0) begin
        rsp_valid = 1'b1;
        rsp_data  = mem_rd(rsp_addr_p);
        rsp_fault = rsp_fault_p;
        rsp_pend  = 1'b0;
      end else rsp_cd--;
    end
    if (prev_v) begin
      // R10 request held until accepted
      chk(req_valid && req_addr == prev_a && req_wdata == prev_d, "R10", "request hold",
          {req_addr, req_wdata}, {prev_a, prev_d});
    end
    req_ready = rst_n && (($urandom % 4) != 0);
    prev_v = req_valid && !req_ready;
    prev_a = req_addr;
    prev_d = req_wdata;
    if (req_valid && req_ready) begin
      if (req_write) begin
        if (exp_wa.size() == 0) chk(0, "R3", "unexpected write", {32'h0, req_addr}, 64'h0);
        else begin
          logic [31:0] ea, ed, old, m;
          ea = exp_wa.pop_front();
          ed = exp_wd.pop_front();
          chk(req_addr == ea && req_wdata == ed, "R5", "write addr/data",
              {req_addr, req_wdata}, {ea, ed});
          m = (req_size == 2'd0) ? 32'hFF : (req_size == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
          old = mem_rd(req_addr);
          mem[req_addr] = (old & ~m) | (req_wdata & m);
        end
      end else begin
        if (exp_rd.size() == 0) chk(0, "R9", "unexpected read", {32'h0, req_addr}, 64'h0);
        else begin
          logic [31:0] ea;
          ea = exp_rd.pop_front();
          chk(req_addr == ea, "R4", "read order/address", {32'h0, req_addr}, {32'h0, ea});
        end
        rsp_pend    = 1'b1;
        rsp_cd      = $urandom % 3;
        rsp_addr_p  = req_addr;
        rsp_fault_p = (rd_idx == fault_at);
        rd_idx++;
      end
    end
  end

  // ---------------- reference ----------------
  function automatic logic [5:0] ref_flags(input int w, input longint unsigned a,
                                           input longint unsigned b);
    longint unsigned m, d;
    logic c, p, h, z, s, o;
    m = (64'd1 << w) - 1;
    d = (a - b) & m;
    c = a < b;
    z = (d == 0);
    s = ((d >> (w - 1)) & 1) != 0;
    o = (((a >> (w - 1)) & 1) != ((b >> (w - 1)) & 1)) &&
        (((d >> (w - 1)) & 1) != ((a >> (w - 1)) & 1));
    h = (((a ^ b ^ d) >> 4) & 1) != 0;
    p = 1'b1;
    for (int i = 0; i < 8; i++) if (((d >> i) & 1) != 0) p = ~p;
    return {o, s, z, h, p, c};
  endfunction

  task automatic run_op(input logic [1:0] sz, input bit isreg, input logic [31:0] a,
                        input logic [31:0] al, input logic [31:0] ah,
                        input logic [31:0] sl, input logic [31:0] sh,
                        input logic [31:0] dreg, input logic [5:0] fl,
                        input int fault, input bit poke, input string tag);
    logic [31:0] m, dlo, dhi, e_lo, e_hi, e_wd;
    logic [5:0]  e_fl;
    bit          memf, mt, ab, e_wr;
    int          w, cyc;
    m    = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    memf = !(isreg && sz != 3);
    dlo  = (memf ? mem_rd(a) : dreg) & m;
    dhi  = mem_rd(a + 4);
    exp_rd.delete(); exp_wa.delete(); exp_wd.delete();
    fault_at = memf ? fault : -1;
    rd_idx   = 0;
    ab   = memf && fault >= 0;
    if (memf) begin
      exp_rd.push_back(a);
      if (sz == 3 && fault != 0) exp_rd.push_back(a + 4);
    end
    mt = (sz == 3) ? (al == dlo && ah == dhi) : ((al & m) == dlo);
    if (!ab && mt && memf) begin
      exp_wa.push_back(a); exp_wd.push_back(sl & m);
      if (sz == 3) begin exp_wa.push_back(a + 4); exp_wd.push_back(sh); end
    end
    e_lo = (ab || mt) ? al : ((al & ~m) | dlo);
    e_hi = (!ab && !mt && sz == 3) ? dhi : ah;
    if (ab)           e_fl = fl;
    else if (sz == 3) e_fl = (fl & 6'b110111) | (mt ? 6'b001000 : 6'b0);
    else              e_fl = ref_flags(w, longint'(al & m), longint'(dlo));
    e_wr = !memf && mt;
    e_wd = (dreg & ~m) | (sl & m);

    op_size = sz; op_is_reg = isreg; op_addr = a; acc_lo_i = al; acc_hi_i = ah;
    src_lo_i = sl; src_hi_i = sh; dst_reg_i = dreg; flags_i = fl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 300) begin
      if (poke && cyc == 2) begin start = 1'b1; acc_lo_i = ~al; end
      @(negedge clk);
      start = 1'b0; acc_lo_i = al;
      cyc++;
    end
    chk(done, tag, "watchdog: done seen", {63'h0, done}, 64'h1);
    if (!memf) chk(cyc == 1, "R9", "register latency", 64'(cyc), 64'd1);
    chk(aborted == ab, (ab ? "R8" : tag), "aborted", {63'h0, aborted}, {63'h0, ab});
    chk(acc_lo_o == e_lo, (ab ? "R8" : (mt ? "R2" : "R3")), "acc_lo_o",
        {32'h0, acc_lo_o}, {32'h0, e_lo});
    chk(acc_hi_o == e_hi, (sz == 3 ? "R5" : "R2"), "acc_hi_o", {32'h0, acc_hi_o}, {32'h0, e_hi});
    chk(flags_o == e_fl, (ab ? "R8" : (sz == 3 ? "R6" : "R1")), "flags_o",
        {58'h0, flags_o}, {58'h0, e_fl});
    chk(cycles_o == (memf ? 4'd10 : 4'd6), "R7", "cycles_o", {60'h0, cycles_o},
        {60'h0, (memf ? 4'd10 : 4'd6)});
    chk(dst_wr == e_wr, "R9", "dst_wr", {63'h0, dst_wr}, {63'h0, e_wr});
    if (e_wr) chk(dst_wdata == e_wd, "R9", "dst_wdata", {32'h0, dst_wdata}, {32'h0, e_wd});
    chk(exp_rd.size() == 0 && exp_wa.size() == 0, (ab ? "R8" : "R5"), "all transfers done",
        64'(exp_rd.size() + exp_wa.size()), 64'd0);
    @(negedge clk);
    chk(!done && !busy, "R11", "single done pulse then idle", {62'h0, done, busy}, 64'h0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !req_valid, "R11", "reset state", {61'h0, done, busy, req_valid}, 64'h0);

    // register forms
    run_op(2'd0, 1, 0, 32'h1234_5642, 0, 32'h0000_0077, 0, 32'hAABB_CC42, 6'h00, -1, 0, "R9");
    run_op(2'd1, 1, 0, 32'hFFFF_0001, 0, 32'h0000_1111, 0, 32'h0000_0002, 6'h00, -1, 0, "R1");

    // memory narrow forms
    mem[32'h100] = 32'hDEAD_BEEF;
    run_op(2'd2, 0, 32'h100, 32'hDEAD_BEEF, 0, 32'h0BAD_F00D, 0, 0, 6'h00, -1, 0, "R2");
    chk(mem[32'h100] == 32'h0BAD_F00D, "R2", "memory updated", {32'h0, mem[32'h100]}, 64'h0BAD_F00D);
    mem[32'h104] = 32'h5555_0010;
    run_op(2'd0, 0, 32'h104, 32'hCAFE_BA21, 0, 32'h99, 0, 0, 6'h00, -1, 0, "R3");
    chk(mem[32'h104] == 32'h5555_0010, "R3", "memory unchanged", {32'h0, mem[32'h104]}, 64'h5555_0010);
    mem[32'h108] = 32'h0000_0001;
    run_op(2'd1, 0, 32'h108, 32'h0000_8000, 0, 0, 0, 0, 6'h00, -1, 0, "R1");
    mem[32'h10C] = 32'h0000_0019;
    run_op(2'd0, 0, 32'h10C, 32'h0000_0008, 0, 0, 0, 0, 6'h00, -1, 0, "R1");

    // 64-bit pair
    mem[32'h200] = 32'h1111_2222; mem[32'h204] = 32'h3333_4444;
    run_op(2'd3, 0, 32'h200, 32'h1111_2222, 32'h3333_4444, 32'hAAAA_0000, 32'hBBBB_0000, 0,
           6'h35, -1, 0, "R5");
    chk(mem[32'h204] == 32'hBBBB_0000, "R5", "high word written", {32'h0, mem[32'h204]}, 64'hBBBB_0000);
    run_op(2'd3, 0, 32'h200, 32'hAAAA_0000, 32'h0000_0001, 32'h1, 32'h2, 0, 6'h08, -1, 0, "R6");
    run_op(2'd3, 1, 32'h200, 32'h0, 32'h0, 32'h1, 32'h2, 0, 6'h3F, -1, 0, "R7");

    // faults
    run_op(2'd2, 0, 32'h300, 32'h0, 0, 32'h5, 0, 0, 6'h2A, 0, 0, "R8");
    mem[32'h400] = 32'h7777_7777; mem[32'h404] = 32'h8888_8888;
    run_op(2'd3, 0, 32'h400, 32'h7777_7777, 32'h8888_8888, 32'h1, 32'h2, 0, 6'h15, 1, 0, "R8");
    chk(mem[32'h400] == 32'h7777_7777, "R8", "no write after fault", {32'h0, mem[32'h400]}, 64'h7777_7777);

    // stray start while busy
    mem[32'h500] = 32'h0000_00AB;
    run_op(2'd0, 0, 32'h500, 32'h0000_00AB, 0, 32'h0000_00CD, 0, 0, 6'h00, -1, 1, "R11");

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [1:0]  sz;
      logic [31:0] a, al, ah;
      bit          isr;
      int          f;
      sz  = 2'($urandom % 4);
      isr = ($urandom % 3) == 0;
      a   = 32'h1000 + 32'(($urandom % 8) * 8);
      al  = $urandom; ah = $urandom;
      if (($urandom % 2) == 0) begin al = mem_rd(a); ah = mem_rd(a + 4); end
      f = (($urandom % 8) == 0) ? int'($urandom % (sz == 3 ? 2 : 1)) : -1;
      run_op(sz, isr, a, al, ah, $urandom, $urandom, (($urandom % 2) == 0) ? al : $urandom,
             6'($urandom), f, (i % 5) == 0, "R1");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule